// File: doc/BRIEF.md
# Nibble-Sliced Dual-Result ALU

This block is a two-operand arithmetic and logic unit for an 8-bit microcoded datapath. It takes two 8-bit operands, a 1-bit carry input and a 4-bit function select. Each select code produces two 8-bit results in parallel. The low result carries data: a sum, a shifted field or an assembled address. The high result carries a companion value, either a packed flag byte or a second, unrelated logic result. A microinstruction can keep whichever of the two it needs.

The arithmetic runs as two chained 4-bit slices. The carry or borrow between the nibbles appears as an auxiliary flag, and parity and zero status are also given per nibble. Flag bytes use a fixed layout: carry in bit 7, signed overflow in bit 6, nibble carry in bit 3. Any flag-byte bit that a function does not define is driven to 0. Both results are registered: they appear one clock after the operands. A synchronous active-high reset clears them.

Top module: `ndsa_alu`

## Requirements
- R1: While reset is high, both results are cleared to 0x00 at the next clock edge. Otherwise each result reflects the operands and select that were present at the previous rising edge, one cycle later.
- R2: Select 2 adds with carry. The low result is A+B+C. In the high result, bit 7 is the carry out of bit 7, bit 6 is the two's-complement overflow and bit 3 is the carry out of bit 3. All other bits are 0.
- R3: Select 3 subtracts with borrow. The low result is A-B-C. In the high result, bit 7 is the borrow out of bit 7, bit 6 is the signed overflow and bit 3 is the borrow out of bit 3. All other bits are 0.
- R4: Select 1 decimal-adjusts A, with B[3] as the incoming nibble carry and B[7] as the incoming carry. The adjustment runs in two steps:
  - First step: add 0x06 if A[3:0] > 9 or B[3] is set.
  - Second step: add 0x60 if the upper part after the first step, including its carry, exceeds 9, or if B[7] is set.

  The high result has bit 7 set when B[7] was set or when either step carries out of bit 7. Bit 3 is the carry out of bit 3 in the first step. All other bits are 0.
- R5: Select 0 gives A^B as the low result. The high result is B with the bit at index A[2:0] inverted.
- R6: Select 4 passes A on the low result. Select 5 gives {3'b0, A[4:3], 2'b0, B[0]} as the low result and A|B as the high result. Select 13 passes B on the low result and gives A&B as the high result. Select 10 gives ~A as the high result.
- R7: Select 4 places the odd parity of A (XOR of all 8 bits) in bit 7 of the high result and the odd parity of A[3:0] in bit 3. All other bits are 0.
- R8: Select 6 gives A with bit B[2:0] replaced by C as the low result, and 0x00 as the high result. Select 7 gives {A[7:4], B[3:0]} as the low result. Its high result has B[A[2:0]] in bit 7 and 0 elsewhere.
- R9: Select 9 merges flags into a status byte {B[7], B[6], A[5:3], B[3], A[1:0]} on the low result. In the high result, bit 7 is 1 when A is zero and bit 3 is 1 when A[3:0] is zero. All other bits are 0.
- R10: Select 12 forms a register-bank address {3'b0, B[4:3], A[2:0]} on the low result. In the high result, bit 7 is 1 when B is zero and bit 3 is 1 when B[3:0] is zero. All other bits are 0.
- R11: Select 10 gives {A[7:3], B[3:1]} as the low result. Select 14 gives {A[7:1], C} as the low result and 0x00 as the high result. Select 15 gives A+C as the low result. Its high result holds the carry out of bit 7 in bit 7 and the carry out of bit 3 in bit 3, with 0 elsewhere.
- R12: Select 8 fills each nibble k of the low result with {valid, prio, idx[1:0]}:
  - idx is the lowest set position of A[4k+3:4k], or 0 if that nibble of A is zero.
  - valid is the OR of that nibble of A.
  - prio is B[4k+idx] ANDed with valid.

  The high result treats A as the in-service byte and B as a selected request. The request is rejected when A[6] is set, or when A[5] is set and B[7] is clear. On rejection the high result is {1, A[6:0]}. Otherwise it is {0, A[6]|B[7], A[5]|~B[7], A[4:3], B[2:0]}.
- R13: Select 11 gives 0x00 on both results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First operand A |
| op_b | input | 8 | Second operand B |
| op_c | input | 1 | Carry / bit input C |
| fn_sel | input | 4 | Function select |
| res_lo | output | 8 | Registered data result |
| res_hi | output | 8 | Registered flag or companion result |

## Verification
The bench targets the slice boundary with these cases:
- Sums and differences that cross bit 3 and bit 7 with and without incoming carry, such as 0x0F+0x00+1, 0xFF+0x01 and 0x80-0x01. A broken nibble chain or an inverted borrow sense would show up as a wrong bit 3 or bit 7, or as a low result off by 16.
- Signed overflow at 0x7F+1 and 0x80-1, where a wrong sign test would miss the flag.
- Decimal adjust at 0x9A, 0x99 with carry set, and 0x0F with nibble carry. These catch a second-step condition that ignores the carry from the first step.
- Bit insert, extract and invert at all eight indices, to expose an off-by-one or swapped index source.
- The in-service update in both reject cases and the accept case, including all-zero request nibbles. A wrong priority encoder or inverted accept bit would show up here.

// File: rtl/ndsa_pkg.sv
package ndsa_pkg;
  localparam int NIB_W  = 4;
  localparam int DATA_W = 2 * NIB_W;
  localparam int SEL_W  = 4;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [SEL_W-1:0] {
    F_XOR_CPL   = 4'd0,
    F_DECADJ    = 4'd1,
    F_ADDC      = 4'd2,
    F_SUBB      = 4'd3,
    F_PASS_PAR  = 4'd4,
    F_IND_OR    = 4'd5,
    F_INSERT    = 4'd6,
    F_NIB_EXT   = 4'd7,
    F_IRQ       = 4'd8,
    F_MERGE_ZA  = 4'd9,
    F_JMP_NOT   = 4'd10,
    F_NULL      = 4'd11,
    F_BANK_ZB   = 4'd12,
    F_PASSB_AND = 4'd13,
    F_SETLSB    = 4'd14,
    F_INCC      = 4'd15
  } fn_e;
endpackage

// File: rtl/ndsa_nib_add.sv
module ndsa_nib_add #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] a,
  input  logic [NIB_W-1:0] b,
  input  logic             cin,
  output logic [NIB_W-1:0] sum,
  output logic             cout
);
  logic [NIB_W:0] wide;
  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
    sum  = wide[NIB_W-1:0];
    cout = wide[NIB_W];
  end
endmodule

// File: rtl/ndsa_irq_pick.sv
module ndsa_irq_pick #(
  parameter int NIB_W = 4,
  localparam int IW   = $clog2(NIB_W)
) (
  input  logic [NIB_W-1:0] req,
  input  logic [NIB_W-1:0] pri,
  output logic             valid,
  output logic             prio,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int j = NIB_W - 1; j >= 0; j--) begin
      if (req[j]) idx = IW'(j);
    end
    valid = |req;
    prio  = valid & pri[idx];
  end
endmodule

// File: rtl/ndsa_bitops.sv
module ndsa_bitops #(
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c,
  output logic [DATA_W-1:0] ins,
  output logic [DATA_W-1:0] cpl,
  output logic              ext
);
  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_bit
      assign ins[i] = (b[IW-1:0] == IW'(i)) ? c     : a[i];
      assign cpl[i] = (a[IW-1:0] == IW'(i)) ? ~b[i] : b[i];
    end
  endgenerate
  assign ext = b[a[IW-1:0]];
endmodule

// File: rtl/ndsa_alu.sv
module ndsa_alu
  import ndsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              op_c,
  input  logic [SEL_W-1:0]  fn_sel,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi
);
  localparam int SLICES = DATA_W / NIB_W;
  localparam int MSB    = DATA_W - 1;
  localparam int NMSB   = NIB_W - 1;

  fn_e fn;
  assign fn = fn_e'(fn_sel);

  // shared nibble adder chain: add, subtract, increment
  logic              is_sub, is_inc;
  logic [DATA_W-1:0] add_b, add_s;
  logic [SLICES:0]   chain;
  assign is_sub   = (fn == F_SUBB);
  assign is_inc   = (fn == F_INCC);
  assign add_b    = is_inc ? '0 : (is_sub ? ~op_b : op_b);
  assign chain[0] = is_sub ? ~op_c : op_c;

  genvar k;
  generate
    for (k = 0; k < SLICES; k++) begin : g_slice
      ndsa_nib_add #(.NIB_W(NIB_W)) u_add (
        .a   (op_a[k*NIB_W +: NIB_W]),
        .b   (add_b[k*NIB_W +: NIB_W]),
        .cin (chain[k]),
        .sum (add_s[k*NIB_W +: NIB_W]),
        .cout(chain[k+1])
      );
    end
  endgenerate

  logic cy_hi, cy_lo, ovf;
  assign cy_hi = is_sub ? ~chain[SLICES] : chain[SLICES];
  assign cy_lo = is_sub ? ~chain[1]      : chain[1];
  assign ovf   = is_sub ? ((op_a[MSB] != op_b[MSB]) && (add_s[MSB] != op_a[MSB]))
                        : ((op_a[MSB] == op_b[MSB]) && (add_s[MSB] != op_a[MSB]));

  // decimal adjust, two correction steps
  logic       da_fix_lo, da_fix_hi, da_lc, da_cy;
  logic [4:0] da_lo5;
  logic [9:0] da_t1, da_t2;
  always_comb begin
    da_fix_lo = (op_a[3:0] > 4'd9) | op_b[3];
    da_lo5    = {1'b0, op_a[3:0]} + 5'd6;
    da_lc     = da_fix_lo & da_lo5[4];
    da_t1     = {2'b0, op_a} + (da_fix_lo ? 10'd6 : 10'd0);
    da_fix_hi = (da_t1[8:4] > 5'd9) | op_b[7];
    da_t2     = da_t1 + (da_fix_hi ? 10'h060 : 10'd0);
    da_cy     = op_b[7] | (|da_t2[9:8]);
  end

  // bit insert / extract / complement
  logic [DATA_W-1:0] bit_ins, bit_cpl;
  logic              bit_ext;
  ndsa_bitops #(.DATA_W(DATA_W)) u_bits (
    .a  (op_a),
    .b  (op_b),
    .c  (op_c),
    .ins(bit_ins),
    .cpl(bit_cpl),
    .ext(bit_ext)
  );

  // per-nibble interrupt candidate
  logic [DATA_W-1:0] irq_word;
  generate
    for (k = 0; k < SLICES; k++) begin : g_irq
      logic       v, p;
      logic [1:0] ix;
      ndsa_irq_pick #(.NIB_W(NIB_W)) u_pick (
        .req  (op_a[k*NIB_W +: NIB_W]),
        .pri  (op_b[k*NIB_W +: NIB_W]),
        .valid(v),
        .prio (p),
        .idx  (ix)
      );
      assign irq_word[k*NIB_W +: NIB_W] = {v, p, ix};
    end
  endgenerate

  logic              isr_rej;
  logic [DATA_W-1:0] isr_word;
  assign isr_rej  = op_a[6] | (op_a[5] & ~op_b[7]);
  assign isr_word = isr_rej ? {1'b1, op_a[6:0]}
                            : {1'b0, op_a[6] | op_b[7], op_a[5] | ~op_b[7],
                               op_a[4:3], op_b[2:0]};

  // function select
  logic [DATA_W-1:0] nxt_lo, nxt_hi;
  always_comb begin
    nxt_lo = '0;
    nxt_hi = '0;
    unique case (fn)
      F_XOR_CPL:   begin nxt_lo = op_a ^ op_b; nxt_hi = bit_cpl; end
      F_DECADJ:    begin nxt_lo = da_t2[7:0]; nxt_hi[MSB] = da_cy; nxt_hi[NMSB] = da_lc; end
      F_ADDC, F_SUBB: begin
        nxt_lo = add_s;
        nxt_hi[MSB] = cy_hi; nxt_hi[MSB-1] = ovf; nxt_hi[NMSB] = cy_lo;
      end
      F_PASS_PAR:  begin nxt_lo = op_a; nxt_hi[MSB] = ^op_a; nxt_hi[NMSB] = ^op_a[NMSB:0]; end
      F_IND_OR:    begin nxt_lo = {3'b0, op_a[4:3], 2'b0, op_b[0]}; nxt_hi = op_a | op_b; end
      F_INSERT:    nxt_lo = bit_ins;
      F_NIB_EXT:   begin nxt_lo = {op_a[7:4], op_b[3:0]}; nxt_hi[MSB] = bit_ext; end
      F_IRQ:       begin nxt_lo = irq_word; nxt_hi = isr_word; end
      F_MERGE_ZA:  begin
        nxt_lo = {op_b[7], op_b[6], op_a[5:3], op_b[3], op_a[1:0]};
        nxt_hi[MSB] = (op_a == '0); nxt_hi[NMSB] = (op_a[NMSB:0] == '0);
      end
      F_JMP_NOT:   begin nxt_lo = {op_a[7:3], op_b[3:1]}; nxt_hi = ~op_a; end
      F_NULL:      ;
      F_BANK_ZB:   begin
        nxt_lo = {3'b0, op_b[4:3], op_a[2:0]};
        nxt_hi[MSB] = (op_b == '0); nxt_hi[NMSB] = (op_b[NMSB:0] == '0);
      end
      F_PASSB_AND: begin nxt_lo = op_b; nxt_hi = op_a & op_b; end
      F_SETLSB:    nxt_lo = {op_a[7:1], op_c};
      F_INCC:      begin nxt_lo = add_s; nxt_hi[MSB] = cy_hi; nxt_hi[NMSB] = cy_lo; end
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      res_lo <= nxt_lo;
      res_hi <= nxt_hi;
    end
  end

  // R1: reset clears both results
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (res_lo == '0 && res_hi == '0));

  // R2: carry and sum form the 9-bit total
  p_add_total_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fn_sel) == 4'd2) |->
      ({res_hi[7], res_lo} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {8'd0, $past(op_c)})));

  // R3: borrow and difference form the 9-bit two's-complement difference
  p_sub_total_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fn_sel) == 4'd3) |->
      ({res_hi[7], res_lo} == ({1'b0, $past(op_a)} - {1'b0, $past(op_b)} - {8'd0, $past(op_c)})));

  // R5: complement touches exactly one bit of B
  p_cpl_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fn_sel) == 4'd0) |->
      ($countones(res_hi ^ $past(op_b)) == 1));

  // R8: insert changes at most one bit of A
  p_insert_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fn_sel) == 4'd6) |->
      ($onehot0(res_lo ^ $past(op_a)) && res_hi == '0));

  // R13: null select yields zeros
  p_null_zero_r13: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fn_sel) == 4'd11) |-> (res_lo == '0 && res_hi == '0));
endmodule

// File: tb/ndsa_alu_tb.sv
`timescale 1ns/1ps
module ndsa_alu_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] op_a, op_b;
  logic       op_c;
  logic [3:0] fn_sel;
  logic [7:0] res_lo, res_hi;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ndsa_alu u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .fn_sel(fn_sel), .res_lo(res_lo), .res_hi(res_hi)
  );

  function automatic string rtag(input logic [3:0] s);
    case (s)
      4'd0:  return "R5";
      4'd1:  return "R4";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R7";
      4'd5:  return "R6";
      4'd6:  return "R8";
      4'd7:  return "R8";
      4'd8:  return "R12";
      4'd9:  return "R9";
      4'd10: return "R11";
      4'd11: return "R13";
      4'd12: return "R10";
      4'd13: return "R6";
      4'd14: return "R11";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic c, input logic [3:0] s);
    logic [7:0] ql, qh;
    int t, lo;
    ql = 8'h00; qh = 8'h00;
    case (s)
      4'd0: begin ql = a ^ b; qh = b; qh[a[2:0]] = ~qh[a[2:0]]; end
      4'd1: begin
        t = int'(a); lo = 0;
        if (int'(a[3:0]) > 9 || b[3]) begin
          lo = (int'(a[3:0]) + 6 > 15) ? 1 : 0;
          t = t + 6;
        end
        if ((t / 16) > 9 || b[7]) t = t + 96;
        ql = t[7:0]; qh[7] = b[7] || (t > 255); qh[3] = (lo == 1);
      end
      4'd2: begin
        t = int'(a) + int'(b) + int'(c);
        ql = t[7:0]; qh[7] = t > 255;
        qh[3] = (int'(a[3:0]) + int'(b[3:0]) + int'(c)) > 15;
        qh[6] = (a[7] == b[7]) && (ql[7] != a[7]);
      end
      4'd3: begin
        t = int'(a) - int'(b) - int'(c);
        ql = t[7:0]; qh[7] = t < 0;
        qh[3] = (int'(a[3:0]) - int'(b[3:0]) - int'(c)) < 0;
        qh[6] = (a[7] != b[7]) && (ql[7] != a[7]);
      end
      4'd4: begin ql = a; qh[7] = ^a; qh[3] = ^a[3:0]; end
      4'd5: begin ql = {3'b0, a[4:3], 2'b0, b[0]}; qh = a | b; end
      4'd6: begin ql = a; ql[b[2:0]] = c; end
      4'd7: begin ql = {a[7:4], b[3:0]}; qh[7] = b[a[2:0]]; end
      4'd8: begin
        for (int n = 0; n < 2; n++) begin
          logic [3:0] rq;
          int ix;
          rq = a[4*n +: 4]; ix = 0;
          for (int j = 3; j >= 0; j--) if (rq[j]) ix = j;
          ql[4*n + 3] = |rq;
          ql[4*n + 2] = (|rq) && b[4*n + ix];
          ql[4*n +: 2] = 2'(ix);
        end
        if (a[6] || (a[5] && !b[7])) qh = {1'b1, a[6:0]};
        else qh = {1'b0, a[6] | b[7], a[5] | ~b[7], a[4:3], b[2:0]};
      end
      4'd9: begin
        ql = {b[7], b[6], a[5:3], b[3], a[1:0]};
        qh[7] = (a == 8'h00); qh[3] = (a[3:0] == 4'h0);
      end
      4'd10: begin ql = {a[7:3], b[3:1]}; qh = ~a; end
      4'd11: ;
      4'd12: begin
        ql = {3'b0, b[4:3], a[2:0]};
        qh[7] = (b == 8'h00); qh[3] = (b[3:0] == 4'h0);
      end
      4'd13: begin ql = b; qh = a & b; end
      4'd14: ql = {a[7:1], c};
      default: begin
        t = int'(a) + int'(c);
        ql = t[7:0]; qh[7] = t > 255; qh[3] = (int'(a[3:0]) + int'(c)) > 15;
      end
    endcase
    return {qh, ql};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got hi=%02h lo=%02h expected hi=%02h lo=%02h",
               tag, got[15:8], got[7:0], exp[15:8], exp[7:0]);
    end
  endtask

  // called at a falling edge: drive, wait one full cycle, compare
  task automatic apply(input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic [3:0] s);
    op_a = a; op_b = b; op_c = c; fn_sel = s;
    @(negedge clk);
    check(rtag(s), {res_hi, res_lo}, model(a, b, c, s));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h1D5A;
    void'($urandom(seed));
    rst = 1'b1; op_a = 8'hFF; op_b = 8'hFF; op_c = 1'b1; fn_sel = 4'd10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {res_hi, res_lo}, 16'h0000);
    rst = 1'b0;

    // R2 corners
    apply(8'h0F, 8'h00, 1'b1, 4'd2);
    apply(8'hFF, 8'h01, 1'b0, 4'd2);
    apply(8'h7F, 8'h01, 1'b0, 4'd2);
    apply(8'h80, 8'h80, 1'b1, 4'd2);
    // R3 corners
    apply(8'h00, 8'h01, 1'b0, 4'd3);
    apply(8'h80, 8'h01, 1'b0, 4'd3);
    apply(8'h10, 8'h00, 1'b1, 4'd3);
    // R4 corners
    apply(8'h9A, 8'h00, 1'b0, 4'd1);
    apply(8'h99, 8'h80, 1'b0, 4'd1);
    apply(8'h0F, 8'h08, 1'b0, 4'd1);
    apply(8'hFA, 8'h00, 1'b0, 4'd1);
    // R8 / R5 every index
    for (int i = 0; i < 8; i++) begin
      apply(8'h5A, 8'(i), 1'b1, 4'd6);
      apply(8'hF0 | 8'(i), 8'hC3, 1'b0, 4'd7);
      apply(8'(i), 8'h96, 1'b0, 4'd0);
    end
    // R12 reject/accept and empty nibbles
    apply(8'h40, 8'h85, 1'b0, 4'd8);
    apply(8'h20, 8'h05, 1'b0, 4'd8);
    apply(8'h20, 8'h83, 1'b0, 4'd8);
    apply(8'h00, 8'h06, 1'b0, 4'd8);
    apply(8'h88, 8'hFF, 1'b0, 4'd8);
    // R9 / R10 zero cases, R11 increment carry
    apply(8'h00, 8'hFF, 1'b0, 4'd9);
    apply(8'h30, 8'h00, 1'b0, 4'd12);
    apply(8'hFF, 8'h00, 1'b1, 4'd15);
    apply(8'h0F, 8'h00, 1'b1, 4'd15);
    // R13 null with busy operands
    apply(8'hFF, 8'hFF, 1'b1, 4'd11);

    // random sweep over every select
    for (int r = 0; r < 60; r++) begin
      for (int s = 0; s < 16; s++) begin
        apply(8'($urandom), 8'($urandom), 1'($urandom), 4'(s));
      end
    end

    // R1 reset in mid-run
    op_a = 8'hFF; op_b = 8'h01; op_c = 1'b1; fn_sel = 4'd2; rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", {res_hi, res_lo}, 16'h0000);
    rst = 1'b0;
    apply(8'h3C, 8'hA5, 1'b0, 4'd13);

    finish_run();
  end
endmodule